// File: doc/BRIEF.md
# Lamp Ballast Mode Sequencer

This block is the digital mode controller of a dimming fluorescent lamp ballast. It takes digitized comparator flags from the analog front end as inputs. These flags report the supply against its two lockout thresholds, the rectified line against its two brown-out thresholds, the shutdown pin against its two thresholds, junction over-temperature, the end of the preheat timer, and the sensed peak bridge current against the over-current limit and against two ignition-detect levels. From these flags it steps the ballast through five modes: lockout, preheat, ignition, dim and a latched fault.

Its outputs steer the surrounding analog and driver circuits. They enable the half-bridge, clamp the preheat timing capacitor, enable over-current detection, pick the peak-current regulation reference, lower the ignition-detect level once detection is armed, and ask the oscillator to return to its maximum frequency. Every input flag is resynchronized inside the block, so the flags may change at any time relative to the clock.

Top module: `ballast_seq`

## Requirements
- R1: While reset is applied and after its release, the mode is lockout (code 0) with the bridge off, the timer clamp on, over-current detection off, the preheat reference selected, the detect level high and the oscillator reset request on.
- R2: Lockout moves to preheat (code 1) only when the supply is above its rising threshold, the line is above its high threshold, shutdown is below its low threshold and the junction is not hot. In preheat the bridge is on, the timer clamp is off, over-current detection is off and the preheat reference is selected.
- R3: From preheat, ignition or dim, the mode returns to lockout when the supply falls below its falling threshold, when the line falls below its low threshold, or when shutdown rises above its high threshold.
- R4: Preheat moves to ignition (code 2) when the preheat timer reports done. In ignition, over-current detection is on and the fixed internal reference is selected.
- R5: In ignition, detection arms when the peak rises above the upper detect level, and arming switches the detect-level output to the lower level. Dim (code 3) is entered only when the peak is below the lower level after arming. A peak below the lower level before arming keeps the mode in ignition.
- R6: In ignition or dim, an over-current peak or over-temperature moves the mode to fault (code 4). In fault the bridge is off, the timer clamp is on and over-current detection is off.
- R7: Fault ignores line loss and a shutdown level that stays high. It exits to lockout when the supply falls below its falling threshold, or when shutdown has gone above its high threshold and then below its low threshold. Preheat then restarts through the normal lockout entry.
- R8: When a lockout condition and a fault condition hold in the same cycle, lockout wins.
- R9: A change on any input flag reaches the mode and outputs on the third rising clock edge after it is applied: two synchronizer stages followed by the mode register.
- R10: The mode output carries lockout=0, preheat=1, ignition=2, dim=3, fault=4. The oscillator reset request is on exactly while the mode is lockout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| vcc_above_on | input | 1 | Supply above rising lockout threshold |
| vcc_above_off | input | 1 | Supply above falling lockout threshold |
| line_above_hi | input | 1 | Line sense above high brown-out threshold |
| line_above_lo | input | 1 | Line sense above low brown-out threshold |
| sd_above_hi | input | 1 | Shutdown above its high threshold |
| sd_above_lo | input | 1 | Shutdown above its low threshold |
| over_temp | input | 1 | Junction over temperature |
| preheat_done | input | 1 | Preheat timer has expired |
| peak_over_limit | input | 1 | Peak current above over-current limit |
| peak_above_arm | input | 1 | Peak current above preheat reference plus 20% |
| peak_above_detect | input | 1 | Peak current above preheat reference plus 10% |
| mode | output | 3 | Current mode code |
| bridge_en | output | 1 | Half-bridge drive enable |
| timer_clear | output | 1 | Hold the preheat timing capacitor at zero |
| ocp_en | output | 1 | Over-current detection enable |
| ref_fixed | output | 1 | Peak reference select: 0 programmable preheat level, 1 fixed internal level |
| detect_low | output | 1 | Ignition-detect level: 0 reference plus 20%, 1 reference plus 10% |
| osc_reset | output | 1 | Request oscillator return to maximum frequency |

## Verification
Every output is a decode of registered state. Each result is therefore due on the third rising edge after an input change: two synchronizer flops, then the mode register. The bench drives inputs on falling edges and samples on falling edges. Its reference model reads each flag pattern two cycles late, which reproduces that pipeline without looking inside the design. Directed checks confirm that a mode has not yet changed two edges after a stimulus and has changed one edge later. Longer holds are used only where a requirement says a stimulus must be ignored.

// File: rtl/ballast_pkg.sv
package ballast_pkg;

  typedef enum logic [2:0] {
    M_UVLO  = 3'd0,
    M_PH    = 3'd1,
    M_IGN   = 3'd2,
    M_DIM   = 3'd3,
    M_FAULT = 3'd4
  } mode_e;

  // Synchronized comparator flags; field order matches the top-level packing.
  typedef struct packed {
    logic vcc_on;
    logic vcc_ok;
    logic line_hi;
    logic line_ok;
    logic sd_hi;
    logic sd_lo;
    logic hot;
    logic tmr_done;
    logic pk_oc;
    logic pk_arm;
    logic pk_det;
  } flags_t;

  localparam int NUM_FLAGS = $bits(flags_t);

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= '0;
    else        pipe_q[0] <= d_in;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= pipe_q[s-1];
      end
    end
  endgenerate

  assign q_out = pipe_q[STAGES-1];

endmodule

// File: rtl/ballast_fsm.sv
module ballast_fsm
  import ballast_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t fl,
  output mode_e  mode_q,
  output logic   armed_q
);

  mode_e mode_d;
  logic  armed_d;
  logic  sd_seen_q, sd_seen_d;
  logic  lock_exit, start_ok, fault_hit;

  always_comb begin
    lock_exit = !fl.vcc_ok || !fl.line_ok || fl.sd_hi;
    start_ok  = fl.vcc_on && fl.line_hi && !fl.sd_lo && !fl.hot;
    fault_hit = fl.pk_oc || fl.hot;
  end

  always_comb begin
    mode_d    = mode_q;
    armed_d   = armed_q;
    sd_seen_d = sd_seen_q;
    case (mode_q)
      M_UVLO: begin
        armed_d   = 1'b0;
        sd_seen_d = 1'b0;
        if (start_ok) mode_d = M_PH;
      end
      M_PH: begin
        if (lock_exit) mode_d = M_UVLO;
        else if (fl.tmr_done) begin
          mode_d  = M_IGN;
          armed_d = 1'b0;
        end
      end
      M_IGN: begin
        if (lock_exit) mode_d = M_UVLO;
        else if (fault_hit) begin
          mode_d    = M_FAULT;
          sd_seen_d = 1'b0;
        end else if (armed_q && !fl.pk_det) mode_d = M_DIM;
        else if (fl.pk_arm) armed_d = 1'b1;
      end
      M_DIM: begin
        if (lock_exit) mode_d = M_UVLO;
        else if (fault_hit) begin
          mode_d    = M_FAULT;
          sd_seen_d = 1'b0;
        end
      end
      M_FAULT: begin
        if (!fl.vcc_ok) mode_d = M_UVLO;
        else if (sd_seen_q && !fl.sd_lo) mode_d = M_UVLO;
        else if (fl.sd_hi) sd_seen_d = 1'b1;
      end
      default: mode_d = M_UVLO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_UVLO;
      armed_q   <= 1'b0;
      sd_seen_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      armed_q   <= armed_d;
      sd_seen_q <= sd_seen_d;
    end
  end

  assert_ph_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PH && $past(mode_q) != M_PH) |-> $past(mode_q) == M_UVLO);

  assert_ign_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_IGN && $past(mode_q) != M_IGN) |-> $past(mode_q) == M_PH);

  assert_dim_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DIM && $past(mode_q) != M_DIM) |-> ($past(mode_q) == M_IGN && $past(armed_q)));

  assert_fault_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FAULT && $past(mode_q) != M_FAULT) |->
      ($past(mode_q) == M_IGN || $past(mode_q) == M_DIM));

  assert_fault_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_FAULT && mode_q != M_FAULT) |-> mode_q == M_UVLO);

  assert_legal_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q inside {M_UVLO, M_PH, M_IGN, M_DIM, M_FAULT});

endmodule

// File: rtl/ballast_outdec.sv
module ballast_outdec
  import ballast_pkg::*;
(
  input  mode_e mode_q,
  input  logic  armed_q,
  output logic  bridge_en,
  output logic  timer_clear,
  output logic  ocp_en,
  output logic  ref_fixed,
  output logic  detect_low,
  output logic  osc_reset
);

  always_comb begin
    bridge_en   = 1'b0;
    timer_clear = 1'b1;
    ocp_en      = 1'b0;
    ref_fixed   = 1'b0;
    detect_low  = 1'b0;
    osc_reset   = 1'b0;
    case (mode_q)
      M_UVLO:  osc_reset = 1'b1;
      M_PH: begin
        bridge_en   = 1'b1;
        timer_clear = 1'b0;
      end
      M_IGN: begin
        bridge_en   = 1'b1;
        timer_clear = 1'b0;
        ocp_en      = 1'b1;
        ref_fixed   = 1'b1;
        detect_low  = armed_q;
      end
      M_DIM: begin
        bridge_en   = 1'b1;
        timer_clear = 1'b0;
        ocp_en      = 1'b1;
        ref_fixed   = 1'b1;
      end
      M_FAULT: ;
      default: osc_reset = 1'b1;
    endcase
  end

endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
  import ballast_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_above_on,
  input  logic       vcc_above_off,
  input  logic       line_above_hi,
  input  logic       line_above_lo,
  input  logic       sd_above_hi,
  input  logic       sd_above_lo,
  input  logic       over_temp,
  input  logic       preheat_done,
  input  logic       peak_over_limit,
  input  logic       peak_above_arm,
  input  logic       peak_above_detect,
  output logic [2:0] mode,
  output logic       bridge_en,
  output logic       timer_clear,
  output logic       ocp_en,
  output logic       ref_fixed,
  output logic       detect_low,
  output logic       osc_reset
);

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[RST_STAGES-1];

  logic [NUM_FLAGS-1:0] raw_vec, sync_vec;
  flags_t               fl;
  mode_e                mode_q;
  logic                 armed_q;

  assign raw_vec = {vcc_above_on, vcc_above_off, line_above_hi, line_above_lo,
                    sd_above_hi, sd_above_lo, over_temp, preheat_done,
                    peak_over_limit, peak_above_arm, peak_above_detect};

  flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_in  (raw_vec),
    .q_out (sync_vec)
  );

  assign fl = flags_t'(sync_vec);

  ballast_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .fl      (fl),
    .mode_q  (mode_q),
    .armed_q (armed_q)
  );

  ballast_outdec u_dec (
    .mode_q      (mode_q),
    .armed_q     (armed_q),
    .bridge_en   (bridge_en),
    .timer_clear (timer_clear),
    .ocp_en      (ocp_en),
    .ref_fixed   (ref_fixed),
    .detect_low  (detect_low),
    .osc_reset   (osc_reset)
  );

  assign mode = mode_q;

endmodule

// File: tb/sim_ballast_seq.sv
`timescale 1ns/1ps
module sim_ballast_seq;

  localparam int VON = 0, VOK = 1, LHI = 2, LOK = 3, SDH = 4, SDL = 5,
                 HOT = 6, TMR = 7, OC = 8, ARM = 9, DET = 10;

  logic clk, rst_n;
  logic [10:0] fv;
  logic [2:0] mode;
  logic bridge_en, timer_clear, ocp_en, ref_fixed, detect_low, osc_reset;

  int checks, failures;
  logic [2:0] m_st;
  logic a_st, s_st;
  logic [10:0] p1, p2;
  bit done;

  ballast_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .vcc_above_on(fv[VON]), .vcc_above_off(fv[VOK]),
    .line_above_hi(fv[LHI]), .line_above_lo(fv[LOK]),
    .sd_above_hi(fv[SDH]), .sd_above_lo(fv[SDL]),
    .over_temp(fv[HOT]), .preheat_done(fv[TMR]),
    .peak_over_limit(fv[OC]), .peak_above_arm(fv[ARM]),
    .peak_above_detect(fv[DET]),
    .mode(mode), .bridge_en(bridge_en), .timer_clear(timer_clear),
    .ocp_en(ocp_en), .ref_fixed(ref_fixed), .detect_low(detect_low),
    .osc_reset(osc_reset)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [4:0] mdl(logic [2:0] m, logic a, logic s, logic [10:0] f);
    logic lk, st, fh;
    logic [2:0] nm;
    logic na, ns;
    nm = m; na = a; ns = s;
    lk = !f[VOK] || !f[LOK] || f[SDH];
    st = f[VON] && f[LHI] && !f[SDL] && !f[HOT];
    fh = f[OC] || f[HOT];
    case (m)
      3'd0: begin na = 0; ns = 0; if (st) nm = 3'd1; end
      3'd1: if (lk) nm = 3'd0; else if (f[TMR]) begin nm = 3'd2; na = 0; end
      3'd2: if (lk) nm = 3'd0;
            else if (fh) begin nm = 3'd4; ns = 0; end
            else if (a && !f[DET]) nm = 3'd3;
            else if (f[ARM]) na = 1;
      3'd3: if (lk) nm = 3'd0; else if (fh) begin nm = 3'd4; ns = 0; end
      3'd4: if (!f[VOK]) nm = 3'd0;
            else if (s && !f[SDL]) nm = 3'd0;
            else if (f[SDH]) ns = 1;
      default: nm = 3'd0;
    endcase
    return {nm, na, ns};
  endfunction

  // {bridge, clear, ocp, ref, detect_low, osc_reset}
  function automatic logic [5:0] dec(logic [2:0] m, logic a);
    case (m)
      3'd1: return 6'b100000;
      3'd2: return {4'b1011, a, 1'b0};
      3'd3: return 6'b101100;
      3'd4: return 6'b010000;
      default: return 6'b010001;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    logic [4:0] nx;
    logic [8:0] got, want;
    nx = mdl(m_st, a_st, s_st, p2);
    @(posedge clk);
    {m_st, a_st, s_st} = nx;
    p2 = p1;
    p1 = fv;
    @(negedge clk);
    got  = {mode, bridge_en, timer_clear, ocp_en, ref_fixed, detect_low, osc_reset};
    want = {m_st, dec(m_st, a_st)};
    chk(got == want, "R9 model", 32'(got), 32'(want));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic chk_mode(input logic [2:0] exp, input string req);
    chk(mode == exp, req, 32'(mode), 32'(exp));
  endtask

  task automatic reach_dim();
    fv[TMR] = 1; run(3); chk_mode(3'd2, "R4 enter ignition"); fv[TMR] = 0;
    fv[ARM] = 1; fv[DET] = 1; run(3);
    fv[ARM] = 0; fv[DET] = 0; run(3); chk_mode(3'd3, "R5 enter dim");
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    fv = '0; rst_n = 1'b0;
    m_st = 3'd0; a_st = 0; s_st = 0; p1 = '0; p2 = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({mode, bridge_en, timer_clear, ocp_en, ref_fixed, detect_low, osc_reset} == 9'b000_010001,
        "R1 in reset", 32'(mode), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({mode, bridge_en, timer_clear, ocp_en, ref_fixed, detect_low, osc_reset} == 9'b000_010001,
        "R1 after release", 32'(mode), 0);
    chk(osc_reset == 1'b1, "R10 osc reset in lockout", 32'(osc_reset), 1);

    // R2: every start condition is needed
    fv[VON] = 1; fv[VOK] = 1; fv[LHI] = 1; fv[LOK] = 1; fv[SDL] = 1;
    run(5); chk_mode(3'd0, "R2 shutdown not low");
    fv[SDL] = 0; fv[HOT] = 1;
    run(5); chk_mode(3'd0, "R2 hot");
    fv[HOT] = 0; fv[LHI] = 0;
    run(5); chk_mode(3'd0, "R2 line not high");
    fv[LHI] = 1;
    run(2); chk_mode(3'd0, "R9 two edges unchanged");
    run(1); chk_mode(3'd1, "R9 third edge preheat");
    chk({bridge_en, timer_clear, ocp_en, ref_fixed, osc_reset} == 5'b10000,
        "R2 preheat outputs", 32'({bridge_en, timer_clear, ocp_en, ref_fixed, osc_reset}), 32'h10);

    // R3: line loss from preheat
    fv[LOK] = 0; run(3); chk_mode(3'd0, "R3 line loss");
    fv[LOK] = 1; run(3); chk_mode(3'd1, "R3 line back");

    // R4
    fv[TMR] = 1; run(3); chk_mode(3'd2, "R4 R10 ignition code 2");
    chk({ocp_en, ref_fixed, detect_low} == 3'b110, "R4 ignition outputs",
        32'({ocp_en, ref_fixed, detect_low}), 32'h6);
    fv[TMR] = 0;

    // R5: two-step detect
    fv[DET] = 1; run(4); fv[DET] = 0; run(5);
    chk_mode(3'd2, "R5 unarmed low peak ignored");
    fv[ARM] = 1; fv[DET] = 1; run(3);
    chk(detect_low == 1'b1, "R5 armed lowers level", 32'(detect_low), 1);
    fv[ARM] = 0; run(4); chk_mode(3'd2, "R5 held while above low level");
    fv[DET] = 0; run(3); chk_mode(3'd3, "R5 R10 dim code 3");

    // R6
    fv[OC] = 1; run(3); chk_mode(3'd4, "R6 R10 fault code 4");
    chk({bridge_en, timer_clear, ocp_en} == 3'b010, "R6 fault outputs",
        32'({bridge_en, timer_clear, ocp_en}), 32'h2);
    fv[OC] = 0;

    // R7: latch behaviour
    fv[LOK] = 0; run(5); chk_mode(3'd4, "R7 line loss ignored");
    fv[LOK] = 1;
    fv[SDH] = 1; fv[SDL] = 1; run(6); chk_mode(3'd4, "R7 shutdown high held");
    fv[SDH] = 0; fv[SDL] = 0; run(3); chk_mode(3'd0, "R7 shutdown cycled");
    run(1); chk_mode(3'd1, "R7 restart preheat");

    // R3: shutdown from ignition
    fv[TMR] = 1; run(3); fv[TMR] = 0;
    fv[SDH] = 1; fv[SDL] = 1; run(3); chk_mode(3'd0, "R3 shutdown high");
    fv[SDH] = 0; fv[SDL] = 0; run(3); chk_mode(3'd1, "R3 restart");

    // R8: lockout beats fault
    fv[TMR] = 1; run(3); fv[TMR] = 0;
    fv[LOK] = 0; fv[OC] = 1; run(3); chk_mode(3'd0, "R8 lockout priority");
    fv[LOK] = 1; fv[OC] = 0; run(3); chk_mode(3'd1, "R8 restart");

    // R3: supply loss from dim
    reach_dim();
    fv[VOK] = 0; run(3); chk_mode(3'd0, "R3 supply loss");
    fv[VOK] = 1; run(3); chk_mode(3'd1, "R3 supply back");

    // R6 hot in dim, then R7 supply exit
    reach_dim();
    fv[HOT] = 1; run(3); chk_mode(3'd4, "R6 over temperature");
    fv[HOT] = 0; run(4); chk_mode(3'd4, "R7 latched after hot clears");
    fv[VOK] = 0; run(3); chk_mode(3'd0, "R7 supply exit");
    fv[VOK] = 1;

    // random phase against the bench model
    void'($urandom(32'd2024));
    for (int i = 0; i < 6000; i++) begin
      fv[VOK] = ($urandom_range(99) < 98);
      fv[VON] = fv[VOK] && ($urandom_range(99) < 92);
      fv[LOK] = ($urandom_range(99) < 98);
      fv[LHI] = fv[LOK] && ($urandom_range(99) < 92);
      fv[SDH] = ($urandom_range(99) < 3);
      fv[SDL] = fv[SDH] || ($urandom_range(99) < 4);
      fv[HOT] = ($urandom_range(99) < 2);
      fv[TMR] = ($urandom_range(99) < 25);
      fv[OC]  = ($urandom_range(99) < 3);
      fv[ARM] = ($urandom_range(99) < 20);
      fv[DET] = fv[ARM] || ($urandom_range(99) < 50);
      cyc();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule